// File: doc/BRIEF.md
# Reference-Compare Timer with Event Flags

The block is a memory-mapped general purpose timer. A 16-bit up counter advances once for every `tick` pulse while the timer is enabled. Each time a count step lands on the programmed reference value, the block records a reference event in an 8-bit event register. That event bit is set whatever the interrupt enables say. An interrupt request is formed from the event bits and their enables, and it stays high until software clears the bits.

Software reaches the block through a plain register bus. The bus has a 2-bit address, a write strobe, 16-bit write data and combinational read data. Address 0 holds the mode register, address 1 the reference register, address 2 the counter and address 3 the event register. Reading the counter does not disturb it. Writing the counter clears it. The event register is cleared by writing ones to the bits to be cleared. An optional restart mode returns the counter to zero after each reference match, which turns the timer into a periodic event source.

Top module: `ref_timer`

## Requirements
- R1: After reset the counter, the mode register, the event register and `irq` are all zero, and the reference register holds 0xFFFF.
- R2: With mode bit 0 (enable) set, each cycle in which `tick` is high adds one to the counter. When enable is clear or `tick` is low, the counter holds its value.
- R3: When mode bit 1 (restart) is clear, the counter steps from 0xFFFF to 0x0000 on the next counting cycle.
- R4: Reading address 2 returns the current counter value, and the read does not change the count sequence.
- R5: Any write to address 2 sets the counter to zero on the next cycle, whatever the data, and this takes priority over a tick in the same cycle.
- R6: Event bit 1 sets on the clock edge where a count step makes the counter equal the reference register. This happens whether or not any interrupt enable is set.
- R7: When restart is set and a count step occurs while the counter equals the reference, the counter loads zero instead of incrementing.
- R8: A write to address 3 clears each event bit whose write-data bit is one and leaves bits written with zero unchanged. Event bits otherwise stay set.
- R9: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: Reading address 3 returns the event register in bits 7:0, with bit 1 as the reference event and bit 0 as the capture event. Bit 0 and bits 15:2 always read zero.
- R11: `irq` is high exactly when event bit 1 is set with mode bit 2 (reference interrupt enable) set, or event bit 0 is set with mode bit 3 (capture interrupt enable) set.
- R12: Writes to address 0 store write-data bits 3:0 as the mode register, and writes to address 1 store the full reference value. Both read back zero-extended at their addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable pulse from an external prescaler |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can act on the same bit in one clock: a count step that lands on the reference, which sets the reference event, and a software write-one-to-clear of that bit. The bench brings the counter to one below the reference in restart mode. It then issues the event clear in the very cycle of the landing tick and expects the bit, and `irq` with its enable on, to remain set. A second collision, a counter write during a tick, is judged by checking that the next read of the counter shows zero. Every other cycle is compared against a behavioural model of the register set.

// File: rtl/ref_timer_pkg.sv
package ref_timer_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 2;
    localparam int EVT_W  = 8;
    localparam int MODE_W = 4;

    // register addresses
    typedef enum logic [ADDR_W-1:0] {
        A_MODE = 2'd0,
        A_REF  = 2'd1,
        A_CNT  = 2'd2,
        A_EVT  = 2'd3
    } addr_e;

    // mode bit positions
    localparam int MB_EN  = 0;
    localparam int MB_RST = 1;
    localparam int MB_RIE = 2;
    localparam int MB_CIE = 3;

    // event bit positions
    localparam int EB_CAP = 0;
    localparam int EB_REF = 1;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  refv;
    } cfg_t;

endpackage

// File: rtl/ref_timer_count.sv
module ref_timer_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         restart,
    input  logic         clr,
    input  logic [W-1:0] ref_val,
    output logic [W-1:0] cnt,
    output logic         hit
);

    logic [W-1:0] cnt_d, cnt_q, nxt;

    always_comb begin
        nxt   = (restart && (cnt_q == ref_val)) ? '0 : cnt_q + 1'b1;
        hit   = advance && (nxt == ref_val);
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (advance)
            cnt_d = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> cnt_q == '0); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && !$past(advance)) |-> $stable(cnt_q)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(advance && !clr && !(restart && cnt_q == ref_val))
        |-> cnt_q == W'($past(cnt_q) + 1'b1)); // R3
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $past(advance && !clr && restart && cnt_q == ref_val) |-> cnt_q == '0); // R7

endmodule

// File: rtl/ref_timer_evt.sv
module ref_timer_evt #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] en_vec,
    output logic [N-1:0] evt,
    output logic         irq
);

    logic [N-1:0] evt_d, evt_q;

    always_comb begin
        // a set in the same cycle as a clear wins
        evt_d = (evt_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign evt = evt_q;
    assign irq = |(evt_q & en_vec);

    AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_vec) & ~evt_q) == '0); // R9
    AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_vec & ~set_vec) & evt_q) == '0); // R8
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_q) & ~$past(clr_vec) & ~evt_q) == '0); // R8

endmodule

// File: rtl/ref_timer.sv
module ref_timer
    import ref_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam logic [CNT_W-1:0] REF_RST = '1;

    cfg_t cfg_d, cfg_q;

    logic             wr_mode, wr_ref, wr_cnt, wr_evt;
    logic             advance, hit;
    logic [CNT_W-1:0] cnt;
    logic [EVT_W-1:0] evt, set_vec, clr_vec, en_vec;

    always_comb begin
        wr_mode = bus_we && (bus_addr == A_MODE);
        wr_ref  = bus_we && (bus_addr == A_REF);
        wr_cnt  = bus_we && (bus_addr == A_CNT);
        wr_evt  = bus_we && (bus_addr == A_EVT);

        cfg_d = cfg_q;
        if (wr_mode) cfg_d.mode = bus_wdata[MODE_W-1:0];
        if (wr_ref)  cfg_d.refv = bus_wdata;

        advance = tick && cfg_q.mode[MB_EN];

        set_vec         = '0;
        set_vec[EB_REF] = hit;     // capture source is absent: bit stays zero

        clr_vec = wr_evt ? bus_wdata[EVT_W-1:0] : '0;

        en_vec         = '0;
        en_vec[EB_REF] = cfg_q.mode[MB_RIE];
        en_vec[EB_CAP] = cfg_q.mode[MB_CIE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode <= '0;
            cfg_q.refv <= REF_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    ref_timer_count #(.W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .restart (cfg_q.mode[MB_RST]),
        .clr     (wr_cnt),
        .ref_val (cfg_q.refv),
        .cnt     (cnt),
        .hit     (hit)
    );

    ref_timer_evt #(.N(EVT_W)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (en_vec),
        .evt     (evt),
        .irq     (irq)
    );

    always_comb begin
        unique case (bus_addr)
            A_MODE:  bus_rdata = {{(CNT_W-MODE_W){1'b0}}, cfg_q.mode};
            A_REF:   bus_rdata = cfg_q.refv;
            A_CNT:   bus_rdata = cnt;
            default: bus_rdata = {{(CNT_W-EVT_W){1'b0}}, evt};
        endcase
    end

    AST_EVT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_EVT) |-> (bus_rdata[CNT_W-1:2] == '0 && !bus_rdata[0])); // R10
    AST_EVT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(advance && cnt != cfg_q.refv && !wr_cnt) && cnt == $past(cfg_q.refv)
        |-> evt[EB_REF]); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.mode[MB_RIE] && !cfg_q.mode[MB_CIE]) |-> !irq); // R11

endmodule

// File: tb/ref_timer_tb.sv
`timescale 1ns/1ps
module ref_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural model state
    int m_cnt, m_ref, m_mode, m_evt;

    always #2.5 clk = ~clk;

    ref_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int m_read(input int a);
        case (a)
            0: return m_mode;
            1: return m_ref;
            2: return m_cnt;
            default: return m_evt;
        endcase
    endfunction

    function automatic bit m_irq();
        return ((m_evt >> 1) & 1) && ((m_mode >> 2) & 1);
    endfunction

    task automatic check(input string tag, input int got, input int exp, input string what);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // one clock: drive at negedge, compare, advance model at posedge
    task automatic step(input string tag, input int a, input bit we, input int wd, input bit tk);
        int nxt;
        bit adv, hit;
        bus_addr  = a[1:0];
        bus_we    = we;
        bus_wdata = wd[15:0];
        tick      = tk;
        #1;
        check(tag, int'(bus_rdata), m_read(a), "rdata");
        check(tag, int'(irq), int'(m_irq()), "irq");
        @(posedge clk);
        adv = tk && (m_mode & 1);
        nxt = (((m_mode >> 1) & 1) && m_cnt == m_ref) ? 0 : (m_cnt + 1) % 65536;
        hit = adv && (nxt == m_ref);
        if (we && a == 2)      m_cnt = 0;
        else if (adv)          m_cnt = nxt;
        if (we && a == 3 && ((wd >> 1) & 1)) m_evt = 0;
        if (hit)               m_evt = 2;
        if (we && a == 0)      m_mode = wd & 'hF;
        if (we && a == 1)      m_ref = wd & 'hFFFF;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        m_cnt = 0; m_ref = 'hFFFF; m_mode = 0; m_evt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values at all four addresses
        for (int a = 0; a < 4; a++) step("R1", a, 0, 0, 0);
        check("R1", int'(irq), 0, "irq after reset");

        // R12: mode and reference readback
        step("R12", 0, 1, 'hFFF5, 0);
        step("R12", 0, 0, 0, 0);
        step("R12", 1, 1, 'h1234, 0);
        step("R12", 1, 0, 0, 0);

        // R2: count with enable, hold with tick low or enable clear
        step("R2", 0, 1, 'h1, 0);
        for (int i = 0; i < 5; i++) step("R2", 2, 0, 0, 1);
        for (int i = 0; i < 3; i++) step("R2", 2, 0, 0, 0);
        step("R2", 0, 1, 'h0, 0);
        for (int i = 0; i < 3; i++) step("R2", 2, 0, 0, 1);
        step("R2", 0, 1, 'h1, 0);

        // R4: repeated reads of the counter while counting
        for (int i = 0; i < 4; i++) step("R4", 2, 0, 0, i % 2);

        // R5: counter write during a tick clears it
        step("R5", 2, 1, 'hABCD, 1);
        step("R5", 2, 0, 0, 0);
        check("R5", int'(bus_rdata), 0, "counter after write");

        // R6: reference event sets with interrupts disabled
        step("R6", 1, 1, 10, 0);
        for (int i = 0; i < 12; i++) step("R6", 3, 0, 0, 1);
        check("R6", int'(bus_rdata), 2, "event after match");
        check("R6", int'(irq), 0, "irq masked");

        // R11: enable gives irq, stays until cleared
        step("R11", 0, 1, 'h5, 0);
        step("R11", 3, 0, 0, 1);
        check("R11", int'(irq), 1, "irq enabled");
        // R8: zero write leaves, one write clears
        step("R8", 3, 1, 'hFD, 0);
        step("R8", 3, 1, 'h2, 0);
        step("R8", 3, 0, 0, 0);
        check("R8", int'(bus_rdata), 0, "event cleared");
        check("R11", int'(irq), 0, "irq after clear");

        // R7: restart mode with reference 3
        step("R7", 1, 1, 3, 0);
        step("R7", 0, 1, 'h7, 0);
        step("R7", 2, 1, 0, 0);
        for (int i = 0; i < 10; i++) step("R7", 2, 0, 0, 1);
        step("R7", 3, 1, 2, 0);

        // R9: clear in the landing cycle, set wins
        step("R9", 2, 1, 0, 0);
        step("R9", 2, 0, 0, 1);
        step("R9", 2, 0, 0, 1);
        step("R9", 3, 1, 'h2, 1);
        step("R9", 3, 0, 0, 0);
        check("R9", int'(bus_rdata), 2, "event kept");
        check("R9", int'(irq), 1, "irq kept");

        // R10: reserved event bits read zero after writing ones
        step("R10", 3, 1, 'hFFFF, 0);
        step("R10", 3, 0, 0, 0);
        check("R10", int'(bus_rdata), 0, "reserved bits");

        // R3: full wrap with restart clear and reference at top
        step("R3", 0, 1, 'h1, 0);
        step("R3", 1, 1, 'hFFFF, 0);
        step("R3", 2, 1, 0, 0);
        for (int i = 0; i < 65535; i++) step("R3", 2, 0, 0, 1);
        check("R3", int'(bus_rdata), 'hFFFF, "counter at top");
        step("R3", 2, 0, 0, 1);
        check("R3", int'(bus_rdata), 0, "counter wrapped");
        step("R3", 3, 0, 0, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule